// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and calendar date in seven packed-BCD registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A prescaler counts pulses of an oscillator-rate enable. Each time it completes a second, the seconds register advances, and carries ripple up through minutes, hours, day, month and year. Month lengths and leap years are derived from the stored month and year. Any year divisible by four is a leap year, with no century handling.

Software loads any register through a synchronous write port and reads any register back through an address-selected read port. A control register at address 7 selects between 24-hour and 12-hour hour coding. It also holds a sticky oscillator-stop flag, which reset sets and only software can clear.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers at addresses 0..6 read 0x00, 0x00, 0x00, 0x00, 0x01, 0x01, 0x00, and the control register at address 7 reads 0x30.
- R2: Seconds advance by one after every TICKS_PER_SEC cycles in which osc_tick_i is high, whether or not those cycles are consecutive. Nothing advances while osc_tick_i is low.
- R3: Seconds (address 0) and minutes (address 1) count BCD 00..59. At 59 they wrap to 00 and carry into the next register.
- R4: With control bit 5 set (24-hour coding), the hour register (address 2) counts BCD 0x00..0x23. Going from 0x23 to 0x00 carries into the day.
- R5: With control bit 5 clear (12-hour coding), hour bit 5 is the PM flag and bits 4:0 hold BCD 01..12. Midnight is 0x12, noon is 0x32, and 0x11 goes to 0x32. The sequence runs 0x12, 0x01 .. 0x11, 0x32, 0x21 .. 0x31, and 0x31 goes back to 0x12 with a carry into the day.
- R6: Day of month (address 4) wraps to 0x01 after 0x28 or 0x29 in month 0x02, after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in all other months. Month 0x02 has 0x29 days when the year is divisible by four.
- R7: Month (address 5) goes from 0x12 to 0x01 on a day rollover and carries into the year (address 6). The year counts BCD 0x00..0x99 and wraps to 0x00.
- R8: Weekday (address 3) counts 0..6, advances on every day rollover, and wraps from 6 to 0.
- R9: A write to addresses 0..6 loads the register, masked to its width: 7, 7, 6, 3, 6, 5 and 8 bits. A write in the same cycle as an increment wins for that register only. Carries out of every register are taken from the values held before the write. A read returns the selected register zero-extended to 8 bits.
- R10: A write to seconds clears the prescaler and discards any second completing in that cycle, so the next advance needs a full TICKS_PER_SEC further pulses.
- R11: Control bit 4 is the oscillator-stop flag. Reset sets it, a write of 0 to that bit clears it, and a write of 1 leaves it unchanged.
- R12: Writing control bit 5 changes the hour coding but leaves the stored hour value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Oscillator-rate enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0..6 time, 7 control) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |

## Verification
Two functions can fall in the same cycle.

The first pairing is a software write against a completed second. The bench writes seconds on the exact cycle the prescaler reaches terminal count. The tick must then be lost, and the following advance must arrive a full second later.

The second pairing is a write against a carry. The bench writes minutes on the cycle that seconds roll from 59 and minutes also hold 59. Minutes must take the written value, while the hour still advances from the pre-write carry.

A behavioural model that holds raw register bytes judges every cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_REGS = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_WDAY  = 3'd3,
    REG_DAY   = 3'd4,
    REG_MONTH = 3'd5,
    REG_YEAR  = 3'd6,
    REG_CTRL  = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_H24_BIT  = 5;
  localparam int unsigned CTRL_STOP_BIT = 4;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // y is two BCD digits; tens parity decides which units digits are multiples of 4
  function automatic logic leap_year(input logic [7:0] y);
    case (y[3:0])
      4'd0, 4'd4, 4'd8: return !y[4];
      4'd2, 4'd6:       return y[4];
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic clr_i,
  output logic sec_pulse_o
);

  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last     = (cnt_q == LAST);
  assign sec_pulse_o = osc_tick_i && !clr_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (osc_tick_i) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  generate
    if (TICKS_PER_SEC > 1) begin : g_spacing_chk
      // R2
      pulse_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_pulse_o |=> !sec_pulse_o);
      // R10
      clr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !sec_pulse_o);
    end
  endgenerate

endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter
  import rtc_cal_pkg::*;
#(
  parameter int unsigned W     = 7,
  parameter int unsigned MIN_V = 0,
  parameter int unsigned RST_V = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] max_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);

  logic [W-1:0] val_q, nxt;
  logic         at_max;

  assign at_max  = (val_q == max_i);
  assign carry_o = inc_i && at_max;
  assign nxt     = at_max ? W'(MIN_V) : W'(bcd_inc(8'(val_q)));
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= W'(RST_V);
    else if (wr_i)  val_q <= wr_data_i;
    else if (inc_i) val_q <= nxt;
  end

  // R3 R6 R7 R8
  wrap_to_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && at_max |=> val_q == W'(MIN_V));

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !wr_i |=> $stable(val_q));

  // R9
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> val_q == $past(wr_data_i));

endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       h24_i,
  input  logic       wr_i,
  input  logic [5:0] wr_data_i,
  output logic [5:0] val_o,
  output logic       carry_o
);

  logic [5:0] val_q, nxt;
  logic       wrap;
  logic       pm;
  logic [4:0] lo;

  assign pm = val_q[5];
  assign lo = val_q[4:0];

  always_comb begin
    wrap = 1'b0;
    if (h24_i) begin
      if (val_q == 6'h23) begin
        nxt  = 6'h00;
        wrap = 1'b1;
      end else begin
        nxt = 6'(bcd_inc({2'b00, val_q}));
      end
    end else begin
      if (lo == 5'h12) begin
        nxt = {pm, 5'h01};
      end else if (lo == 5'h11) begin
        nxt  = {~pm, 5'h12};
        wrap = pm;
      end else begin
        nxt = {pm, 5'(bcd_inc({3'b000, lo}))};
      end
    end
  end

  assign carry_o = inc_i && wrap;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= 6'h00;
    else if (wr_i)  val_q <= wr_data_i;
    else if (inc_i) val_q <= nxt;
  end

  // R4
  h24_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && h24_i && val_q == 6'h23 |=> val_q == 6'h00);

  // R5
  pm_midnight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && !h24_i && val_q == 6'h31 |=> val_q == 6'h12);

  // R5
  am_noon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && !h24_i && val_q == 6'h11 |=> val_q == 6'h32);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned MS_N = 2;

  logic [N_REGS-1:0] wr_sel;
  logic              sec_pulse;
  logic [MS_N:0]     ms_inc;
  logic [6:0]        ms_val [MS_N];
  logic [5:0]        hour_val;
  logic              hour_carry;
  logic [2:0]        wday_val;
  logic              wday_carry;
  logic [5:0]        day_val, day_max;
  logic              day_carry;
  logic [4:0]        mon_val;
  logic              mon_carry;
  logic [7:0]        year_val;
  logic              year_carry;
  logic              h24_q, stop_q;

  assign wr_sel = wr_en_i ? (N_REGS'(1) << wr_addr_i) : '0;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .clr_i      (wr_sel[REG_SEC]),
    .sec_pulse_o(sec_pulse)
  );

  assign ms_inc[0] = sec_pulse;

  // seconds then minutes, same shape
  for (genvar i = 0; i < MS_N; i++) begin : g_ms
    rtc_bcd_counter #(.W(7), .MIN_V(0), .RST_V(0)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (ms_inc[i]),
      .max_i    (7'h59),
      .wr_i     (wr_sel[int'(REG_SEC) + i]),
      .wr_data_i(wr_data_i[6:0]),
      .val_o    (ms_val[i]),
      .carry_o  (ms_inc[i+1])
    );
  end

  rtc_hour_counter u_hour (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (ms_inc[MS_N]),
    .h24_i    (h24_q),
    .wr_i     (wr_sel[REG_HOUR]),
    .wr_data_i(wr_data_i[5:0]),
    .val_o    (hour_val),
    .carry_o  (hour_carry)
  );

  assign day_max = month_len(mon_val, year_val);

  rtc_bcd_counter #(.W(6), .MIN_V(1), .RST_V(1)) u_day (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (hour_carry),
    .max_i    (day_max),
    .wr_i     (wr_sel[REG_DAY]),
    .wr_data_i(wr_data_i[5:0]),
    .val_o    (day_val),
    .carry_o  (day_carry)
  );

  rtc_bcd_counter #(.W(3), .MIN_V(0), .RST_V(0)) u_wday (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (hour_carry),
    .max_i    (3'd6),
    .wr_i     (wr_sel[REG_WDAY]),
    .wr_data_i(wr_data_i[2:0]),
    .val_o    (wday_val),
    .carry_o  (wday_carry)
  );

  rtc_bcd_counter #(.W(5), .MIN_V(1), .RST_V(1)) u_month (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (day_carry),
    .max_i    (5'h12),
    .wr_i     (wr_sel[REG_MONTH]),
    .wr_data_i(wr_data_i[4:0]),
    .val_o    (mon_val),
    .carry_o  (mon_carry)
  );

  rtc_bcd_counter #(.W(8), .MIN_V(0), .RST_V(0)) u_year (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (mon_carry),
    .max_i    (8'h99),
    .wr_i     (wr_sel[REG_YEAR]),
    .wr_data_i(wr_data_i),
    .val_o    (year_val),
    .carry_o  (year_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h24_q  <= 1'b1;
      stop_q <= 1'b1;
    end else if (wr_sel[REG_CTRL]) begin
      h24_q <= wr_data_i[CTRL_H24_BIT];
      if (!wr_data_i[CTRL_STOP_BIT]) stop_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr_i))
      REG_SEC:   rd_data_o = 8'(ms_val[0]);
      REG_MIN:   rd_data_o = 8'(ms_val[1]);
      REG_HOUR:  rd_data_o = 8'(hour_val);
      REG_WDAY:  rd_data_o = 8'(wday_val);
      REG_DAY:   rd_data_o = 8'(day_val);
      REG_MONTH: rd_data_o = 8'(mon_val);
      REG_YEAR:  rd_data_o = year_val;
      default: begin
        rd_data_o = '0;
        rd_data_o[CTRL_H24_BIT]  = h24_q;
        rd_data_o[CTRL_STOP_BIT] = stop_q;
      end
    endcase
  end

  // R11
  stop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_q |=> !stop_q);

  // R12
  hour_keep_on_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[REG_CTRL] && !hour_carry && !ms_inc[MS_N] |=> $stable(hour_val));

  // R8
  wday_day_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_carry |-> hour_carry);

  // R7
  year_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_carry && !wr_sel[REG_YEAR] |=> year_val == 8'h00);

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/100ps
module test_rtc_calendar_core;

  localparam int T = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  rtc_calendar_core #(.TICKS_PER_SEC(T)) i_rtc_calendar_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_tick_i(osc_tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int m_reg [7];
  int m_h24, m_stop, m_pc;
  bit done = 1'b0;

  function automatic int bin(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction

  function automatic int h_dec(int raw, int h24);
    int h;
    if (h24 != 0) return bin(raw & 63);
    h = bin(raw & 31);
    if (h == 12) h = 0;
    if ((raw & 32) != 0) h += 12;
    return h;
  endfunction

  function automatic int h_enc(int h, int h24);
    if (h24 != 0) return bcd(h);
    if (h > 12) return 32 | bcd(h - 12);
    if (h == 12) return 32 | 8'h12;
    if (h == 0) return 8'h12;
    return bcd(h);
  endfunction

  function automatic int dim(int mon, int yr);
    int m, y;
    m = bin(mon);
    y = bin(yr);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int mask(int a);
    case (a)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3: return 8'h07;
      5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag(int a);
    case (a)
      0, 1: return "R3";
      2: return (m_h24 != 0) ? "R4" : "R5";
      3: return "R8";
      4: return "R6";
      5, 6: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int exp_rd(int a);
    if (a < 7) return m_reg[a];
    return (m_h24 << 5) | (m_stop << 4);
  endfunction

  task automatic check(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %02h exp %02h", req, what, got, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    rd_addr_i = 3'(a);
    #0.1;
    v = int'(rd_data_o);
  endtask

  task automatic compare_all();
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check(tag(a), v, exp_rd(a), $sformatf("model addr %0d", a));
    end
  endtask

  task automatic model_reset();
    m_reg = '{0, 0, 0, 0, 1, 1, 0};
    m_h24 = 1;
    m_stop = 1;
    m_pc = 0;
  endtask

  task automatic model_step();
    int n [7];
    bit pulse;
    int s, mi, h, d, mo;
    pulse = 1'b0;
    for (int k = 0; k < 7; k++) n[k] = m_reg[k];
    if (wr_en_i && wr_addr_i == 3'd0) m_pc = 0;
    else if (osc_tick_i) begin
      if (m_pc == T - 1) begin m_pc = 0; pulse = 1'b1; end
      else m_pc++;
    end
    if (pulse) begin
      s = bin(m_reg[0]);
      n[0] = bcd((s == 59) ? 0 : s + 1);
      if (s == 59) begin
        mi = bin(m_reg[1]);
        n[1] = bcd((mi == 59) ? 0 : mi + 1);
        if (mi == 59) begin
          h = h_dec(m_reg[2], m_h24);
          n[2] = h_enc((h + 1) % 24, m_h24);
          if (h == 23) begin
            n[3] = bcd((bin(m_reg[3]) + 1) % 7);
            d = bin(m_reg[4]);
            n[4] = bcd((d == dim(m_reg[5], m_reg[6])) ? 1 : d + 1);
            if (d == dim(m_reg[5], m_reg[6])) begin
              mo = bin(m_reg[5]);
              n[5] = bcd((mo == 12) ? 1 : mo + 1);
              if (mo == 12) n[6] = bcd((bin(m_reg[6]) + 1) % 100);
            end
          end
        end
      end
    end
    if (wr_en_i) begin
      if (wr_addr_i < 3'd7) n[wr_addr_i] = int'(wr_data_i) & mask(int'(wr_addr_i));
      else begin
        m_h24 = int'(wr_data_i[5]);
        if (!wr_data_i[4]) m_stop = 0;
      end
    end
    for (int k = 0; k < 7; k++) m_reg[k] = n[k];
  endtask

  // called at a negedge; applies inputs for one cycle, then compares
  task automatic cyc(bit tick, bit wr, int addr, int data);
    osc_tick_i = tick;
    wr_en_i    = wr;
    wr_addr_i  = 3'(addr);
    wr_data_i  = 8'(data);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    osc_tick_i = 1'b0;
    wr_en_i    = 1'b0;
    compare_all();
  endtask

  task automatic wr(int addr, int data); cyc(1'b0, 1'b1, addr, data); endtask
  task automatic run(int n); for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 0, 0); endtask

  task automatic set_time(int yr, int mon, int day, int hr, int mn, int sc);
    wr(6, yr); wr(5, mon); wr(4, day); wr(2, hr); wr(1, mn); wr(0, sc);
  endtask

  task automatic expect_reg(string req, int a, int exp);
    int v;
    rd(a, v);
    check(req, v, exp, $sformatf("addr %0d", a));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
    expect_reg("R1", 2, 8'h00); expect_reg("R1", 3, 8'h00);
    expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
    expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h30);

    // R3 seconds/minutes wrap
    wr(0, 8'h55);
    run(6 * T);
    expect_reg("R3", 0, 8'h01);
    expect_reg("R3", 1, 8'h01);

    // R10 seconds write restarts the prescaler
    wr(0, 8'h10);
    run(T - 1);
    expect_reg("R10", 0, 8'h10);
    run(1);
    expect_reg("R10", 0, 8'h11);
    run(T - 1);
    cyc(1'b1, 1'b1, 0, 8'h20);   // terminal tick coincides with write
    expect_reg("R10", 0, 8'h20);
    run(T - 1);
    expect_reg("R10", 0, 8'h20);
    run(1);
    expect_reg("R10", 0, 8'h21);

    // R2 gapped oscillator enable
    for (int k = 0; k < T; k++) begin
      cyc(1'b0, 1'b0, 0, 0);
      cyc(1'b1, 1'b0, 0, 0);
    end
    expect_reg("R2", 0, 8'h22);
    repeat (5) cyc(1'b0, 1'b0, 0, 0);
    expect_reg("R2", 0, 8'h22);

    // R6 non-leap February, R8 weekday wrap, R4 hour wrap
    wr(3, 6);
    set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(T);
    expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h03);
    expect_reg("R8", 3, 8'h00); expect_reg("R4", 2, 8'h00);

    // R6 leap February
    set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(T);
    expect_reg("R6", 4, 8'h29);
    set_time(8'h04, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    run(T);
    expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h03);

    // R6 thirty-day month
    set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    run(T);
    expect_reg("R6", 4, 8'h01); expect_reg("R6", 5, 8'h05);

    // R7 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    run(T);
    expect_reg("R7", 5, 8'h01); expect_reg("R7", 6, 8'h00);
    expect_reg("R7", 4, 8'h01);

    // R12 mode change keeps hour; R11 write 0 clears stop
    wr(2, 8'h09);
    wr(7, 8'h00);
    expect_reg("R12", 2, 8'h09);
    expect_reg("R11", 7, 8'h00);
    wr(7, 8'h10);
    expect_reg("R11", 7, 8'h00);

    // R5 12-hour sequence
    set_time(8'h20, 8'h01, 8'h05, 8'h11, 8'h59, 8'h59);
    run(T);
    expect_reg("R5", 2, 8'h32);
    wr(1, 8'h59); wr(0, 8'h59);
    run(T);
    expect_reg("R5", 2, 8'h21);
    wr(2, 8'h31); wr(1, 8'h59); wr(0, 8'h59);
    run(T);
    expect_reg("R5", 2, 8'h12);
    expect_reg("R5", 4, 8'h06);
    wr(1, 8'h59); wr(0, 8'h59);
    run(T);
    expect_reg("R5", 2, 8'h01);

    // R9 width masking on write
    wr(4, 8'hFF); expect_reg("R9", 4, 8'h3F);
    wr(3, 8'hFF); expect_reg("R9", 3, 8'h07);
    wr(2, 8'hFF); expect_reg("R9", 2, 8'h3F);
    wr(5, 8'hFF); expect_reg("R9", 5, 8'h1F);
    wr(4, 8'h01); wr(3, 8'h00); wr(5, 8'h01);

    // R9 minute write on the cycle seconds carry into a minute at 59
    wr(7, 8'h20);
    wr(2, 8'h05); wr(1, 8'h59); wr(0, 8'h59);
    run(T - 1);
    cyc(1'b1, 1'b1, 1, 8'h30);
    expect_reg("R9", 0, 8'h00);
    expect_reg("R9", 1, 8'h30);
    expect_reg("R9", 2, 8'h06);
    rd(7, v);
    check("R12", v, 8'h20, "ctrl after mode write");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule